// File: doc/BRIEF.md
# Page-Aligned Write Splitter

This block sits in front of a serial NOR flash command sequencer. A client hands it one write: a start address, a byte count, and then the data bytes. The block cuts the write into page-program requests, none of which crosses a 256-byte page. The first request is trimmed so that it ends on the next page boundary. Each later request covers a whole page, except the tail, which covers whatever bytes remain.

The block keeps one page request in flight at a time. For each request it opens a byte gate that passes exactly that many bytes from the client stream to the sequencer. It then waits for the sequencer's completion. A nonzero completion status aborts the whole write. Before any page is issued, the full range is checked against the device size. A zero-length write finishes at once.

When the block finishes, it returns a one-cycle reply. The reply carries a status kind, the sequencer's error code (when there is one), and the number of bytes that were committed before the block stopped.

The controller has five states. IDLE accepts a request. CHECK tests for zero length and for range. ISSUE offers a page request. WAIT passes data and waits for the completion. REPLY presents the result. The transitions are:
- IDLE→CHECK when a request is accepted.
- CHECK→REPLY for a zero-length request or an out-of-range request; CHECK→ISSUE otherwise.
- ISSUE→WAIT when the sequencer accepts the page request.
- WAIT→ISSUE when a chunk succeeds and bytes remain.
- WAIT→REPLY when the last chunk succeeds, or when any chunk fails.
- REPLY→IDLE after one cycle.

Top module: `page_write_splitter`

## Requirements
- R1: Every page request satisfies (pg_addr mod 256) + pg_len ≤ 256. The page offset is the low 8 address bits, and each length equals min(bytes remaining, 256 − offset).
- R2: The first page request starts at the request address. Each later request starts at the previous address plus the previous length, and no page request has length zero.
- R3: Any chunk that is neither the first nor the last of a write has length 256.
- R4: A successful write replies with rsp_status = 0 (ok), rsp_code = 0 and rsp_count equal to the request length.
- R5: If length is nonzero and address + length exceeds DEV_BYTES, no page request is issued, and the reply carries rsp_status = 1 (range), rsp_count = 0 and rsp_code = 0.
- R6: A zero-length write, at any address, issues no page request and replies with rsp_status = 0 and rsp_count = 0.
- R7: A completion with nonzero pg_status ends the write. No further page request is issued, and the reply carries rsp_status = 2 (page failure), rsp_code = that pg_status, and rsp_count = the sum of the lengths of the chunks that completed with status 0.
- R8: At most one page request is in flight. After pg_valid and pg_ready coincide, pg_valid stays low until pg_done. While pg_valid is high and pg_ready is low, pg_addr and pg_len hold their values.
- R9: A byte moves from the in_ stream to the out_ stream only after a page request has been accepted and before pg_len of its bytes have passed. Data and order are unchanged. At all other times out_valid and in_ready are 0.
- R10: req_ready is 1 only while no write is in progress, and rsp_valid is high for exactly one cycle per write.
- R11: After reset: req_ready = 1, pg_valid = 0, rsp_valid = 0, and out_valid = 0 even when in_valid is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Write request offered |
| req_ready | output | 1 | Block is idle and takes the request |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Byte count |
| rsp_valid | output | 1 | One-cycle reply strobe |
| rsp_status | output | 2 | 0 ok, 1 range, 2 page failure |
| rsp_code | output | ERR_W | Sequencer code on a page failure, else 0 |
| rsp_count | output | LEN_W | Bytes committed |
| pg_valid | output | 1 | Page-program request offered |
| pg_ready | input | 1 | Sequencer accepts the page request |
| pg_addr | output | ADDR_W | Page request start address |
| pg_len | output | PLEN_W | Page request length, 1 to 256 |
| pg_done | input | 1 | Completion of the in-flight page request |
| pg_status | input | ERR_W | Completion status, 0 = success |
| in_valid | input | 1 | Client byte valid |
| in_ready | output | 1 | Client byte taken |
| in_data | input | DATA_W | Client byte |
| out_valid | output | 1 | Byte to sequencer valid |
| out_ready | input | 1 | Sequencer takes byte |
| out_data | output | DATA_W | Byte to sequencer |

## Verification
The embedded properties check, on every cycle, the rules that hold for each request separately: no page request crosses a boundary, no chunk is empty, a stalled request stays stable, only one request is in flight, the reply lasts one cycle, and a range reply reports zero bytes. The byte gate's own properties check that it is empty when it is loaded and that it closes after the last byte of a chunk. Some behaviour depends on the whole sequence of chunks, and only the bench's scenarios can show it. This covers how a trimmed first chunk links to the full pages after it, the byte count reported after an abort in the middle of a write, and the exact ending at the device boundary. The bench's cycle model of the busy flag and of the gate fill level also confirms, on every clock, that bytes pass only inside an accepted chunk.

// File: rtl/pws_pkg.sv
package pws_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_ISSUE,
        ST_WAIT,
        ST_REPLY
    } pws_state_e;

    typedef enum logic [1:0] {
        RS_OK        = 2'b00,
        RS_RANGE     = 2'b01,
        RS_PAGE_FAIL = 2'b10
    } pws_status_e;

endpackage

// File: rtl/pws_chunk_calc.sv
module pws_chunk_calc #(
    parameter int PAGE_BYTES = 256,
    parameter int LEN_W      = 23,
    localparam int PAGE_LG   = $clog2(PAGE_BYTES),
    localparam int PLEN_W    = PAGE_LG + 1
) (
    input  logic [PAGE_LG-1:0] page_off,
    input  logic [LEN_W-1:0]   remain,
    output logic [PLEN_W-1:0]  chunk_len
);

    logic [PLEN_W-1:0] room;
    logic              tail_fits;

    always_comb begin
        room      = PLEN_W'(PAGE_BYTES) - PLEN_W'(page_off);
        tail_fits = remain < LEN_W'(room);
        chunk_len = tail_fits ? remain[PLEN_W-1:0] : room;
    end

endmodule

// File: rtl/pws_range_check.sv
module pws_range_check #(
    parameter int DEV_BYTES = 4194304,
    parameter int ADDR_W    = 22,
    parameter int LEN_W     = 23,
    localparam int SUM_W    = LEN_W + 1
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [LEN_W-1:0]  count,
    output logic              fits
);

    logic [SUM_W-1:0] span_end;

    always_comb begin
        span_end = SUM_W'(base) + SUM_W'(count);
        fits     = span_end <= SUM_W'(DEV_BYTES);
    end

endmodule

// File: rtl/pws_data_gate.sv
module pws_data_gate #(
    parameter int CNT_W  = 9,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CNT_W-1:0]  load_cnt,
    input  logic              flush,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);

    logic [CNT_W-1:0] left_q;
    logic             open;
    logic             fire;

    always_comb begin
        open      = left_q != '0;
        out_valid = in_valid && open;
        in_ready  = out_ready && open;
        out_data  = in_data;
        fire      = out_valid && out_ready;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (flush) begin
            left_q <= '0;
        end else if (load) begin
            left_q <= load_cnt;
        end else if (fire) begin
            left_q <= left_q - 1'b1;
        end
    end

    AST_GATE_LOAD_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (left_q == '0)); // R8

    AST_GATE_CLOSES_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && left_q == CNT_W'(1) && !load && !flush) |=> !out_valid); // R9

endmodule

// File: rtl/page_write_splitter.sv
module page_write_splitter
    import pws_pkg::*;
#(
    parameter int DEV_BYTES  = 4194304,
    parameter int PAGE_BYTES = 256,
    parameter int DATA_W     = 8,
    parameter int ERR_W      = 4,
    localparam int ADDR_W    = $clog2(DEV_BYTES),
    localparam int LEN_W     = ADDR_W + 1,
    localparam int PAGE_LG   = $clog2(PAGE_BYTES),
    localparam int PLEN_W    = PAGE_LG + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    output logic              rsp_valid,
    output logic [1:0]        rsp_status,
    output logic [ERR_W-1:0]  rsp_code,
    output logic [LEN_W-1:0]  rsp_count,
    output logic              pg_valid,
    input  logic              pg_ready,
    output logic [ADDR_W-1:0] pg_addr,
    output logic [PLEN_W-1:0] pg_len,
    input  logic              pg_done,
    input  logic [ERR_W-1:0]  pg_status,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);

    pws_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  remain_q;
    logic [LEN_W-1:0]  committed_q;
    pws_status_e       status_q;
    logic [ERR_W-1:0]  code_q;

    logic [PLEN_W-1:0] chunk;
    logic              span_fits;
    logic              last_chunk;
    logic              page_fail;
    logic              issue_fire;

    pws_chunk_calc #(
        .PAGE_BYTES (PAGE_BYTES),
        .LEN_W      (LEN_W)
    ) i_chunk (
        .page_off  (addr_q[PAGE_LG-1:0]),
        .remain    (remain_q),
        .chunk_len (chunk)
    );

    pws_range_check #(
        .DEV_BYTES (DEV_BYTES),
        .ADDR_W    (ADDR_W),
        .LEN_W     (LEN_W)
    ) i_range (
        .base  (addr_q),
        .count (remain_q),
        .fits  (span_fits)
    );

    pws_data_gate #(
        .CNT_W  (PLEN_W),
        .DATA_W (DATA_W)
    ) i_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (issue_fire),
        .load_cnt  (chunk),
        .flush     (pg_done && state_q == ST_WAIT),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );

    always_comb begin
        last_chunk = remain_q == LEN_W'(chunk);
        page_fail  = pg_status != '0;
        issue_fire = (state_q == ST_ISSUE) && pg_ready;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_CHECK;
            ST_CHECK: begin
                if (remain_q == '0 || !span_fits) state_d = ST_REPLY;
                else                              state_d = ST_ISSUE;
            end
            ST_ISSUE: if (pg_ready) state_d = ST_WAIT;
            ST_WAIT: begin
                if (pg_done) begin
                    if (page_fail || last_chunk) state_d = ST_REPLY;
                    else                         state_d = ST_ISSUE;
                end
            end
            ST_REPLY: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // write context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q      <= '0;
            remain_q    <= '0;
            committed_q <= '0;
            status_q    <= RS_OK;
            code_q      <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        addr_q      <= req_addr;
                        remain_q    <= req_len;
                        committed_q <= '0;
                        status_q    <= RS_OK;
                        code_q      <= '0;
                    end
                end
                ST_CHECK: begin
                    if (remain_q != '0 && !span_fits) status_q <= RS_RANGE;
                end
                ST_WAIT: begin
                    if (pg_done) begin
                        if (page_fail) begin
                            status_q <= RS_PAGE_FAIL;
                            code_q   <= pg_status;
                        end else begin
                            addr_q      <= addr_q + ADDR_W'(chunk);
                            remain_q    <= remain_q - LEN_W'(chunk);
                            committed_q <= committed_q + LEN_W'(chunk);
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready  = state_q == ST_IDLE;
        pg_valid   = state_q == ST_ISSUE;
        pg_addr    = addr_q;
        pg_len     = chunk;
        rsp_valid  = state_q == ST_REPLY;
        rsp_status = status_q;
        rsp_code   = code_q;
        rsp_count  = committed_q;
    end

    AST_PAGE_NO_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
        pg_valid |-> ((PLEN_W+1)'(pg_addr[PAGE_LG-1:0]) + (PLEN_W+1)'(pg_len)
                      <= (PLEN_W+1)'(PAGE_BYTES))); // R1

    AST_CHUNK_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        pg_valid |-> (pg_len != '0)); // R2

    AST_PG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pg_valid && !pg_ready) |=> (pg_valid && $stable(pg_addr) && $stable(pg_len))); // R8

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        (pg_valid && pg_ready) |=> !pg_valid); // R8

    AST_REPLY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R10

    AST_OK_ALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == RS_OK) |-> (remain_q == '0)); // R4

    AST_RANGE_NO_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == RS_RANGE) |-> (rsp_count == '0)); // R5

endmodule

// File: tb/test_page_write_splitter.sv
`timescale 1ns/1ps
module test_page_write_splitter;
    localparam int DEV = 4194304;
    localparam int AW  = 22;
    localparam int LW  = 23;
    localparam int PLW = 9;
    localparam int EW  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          req_valid = 0, req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [LW-1:0] req_len = '0;
    logic          rsp_valid;
    logic [1:0]    rsp_status;
    logic [EW-1:0] rsp_code;
    logic [LW-1:0] rsp_count;
    logic          pg_valid, pg_ready = 0;
    logic [AW-1:0] pg_addr;
    logic [PLW-1:0] pg_len;
    logic          pg_done = 0;
    logic [EW-1:0] pg_status = '0;
    logic          in_valid = 0, in_ready;
    logic [7:0]    in_data = '0;
    logic          out_valid, out_ready = 1;
    logic [7:0]    out_data;

    page_write_splitter i_page_write_splitter (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_len(req_len),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_code(rsp_code), .rsp_count(rsp_count),
        .pg_valid(pg_valid), .pg_ready(pg_ready), .pg_addr(pg_addr), .pg_len(pg_len),
        .pg_done(pg_done), .pg_status(pg_status),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    int checks = 0;
    int fails  = 0;
    int byte_idx = 0;

    task automatic check(string tag, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // cycle model: busy flag and gate fill level, compared every clock
    int model_busy = 0;
    int model_left = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            model_busy = 0;
            model_left = 0;
        end else begin
            check("R10", "req_ready vs model", req_ready, model_busy == 0);
            check("R9", "out_valid vs model", out_valid, in_valid && model_left > 0);
            check("R9", "in_ready vs model", in_ready, out_ready && model_left > 0);
            if (req_valid && req_ready) model_busy = 1;
            if (rsp_valid) model_busy = 0;
            if (pg_done) model_left = 0;
            else if (pg_valid && pg_ready) model_left = int'(pg_len);
            else if (out_valid && out_ready) model_left--;
        end
    end

    task automatic do_write(int addr, int len, int err_at, int code, bit stall);
        int chunks[$];
        int a = addr;
        int r = len;
        int committed = 0;
        bit range_bad = (len != 0) && (addr + len > DEV);
        bit aborted = 0;
        int exp_status;
        if (!range_bad) begin
            while (r > 0) begin
                int off = a % 256;
                int c = (r < 256 - off) ? r : 256 - off;
                chunks.push_back(c);
                a += c;
                r -= c;
            end
        end
        @(negedge clk);
        req_valid = 1; req_addr = AW'(addr); req_len = LW'(len);
        @(negedge clk);
        req_valid = 0;
        a = addr;
        foreach (chunks[i]) begin
            int t = 0;
            while (!pg_valid && t < 60) begin
                @(negedge clk);
                t++;
            end
            check("R2", "page request seen", pg_valid, 1);
            check("R2", "page address", pg_addr, a);
            check("R1", "page length", pg_len, chunks[i]);
            if (i > 0 && i < chunks.size() - 1) check("R3", "middle chunk full", pg_len, 256);
            if (stall) begin
                repeat (3) begin
                    @(negedge clk);
                    check("R8", "held valid", pg_valid, 1);
                    check("R8", "held address", pg_addr, a);
                    check("R8", "held length", pg_len, chunks[i]);
                end
            end
            pg_ready = 1;
            @(negedge clk);
            pg_ready = 0;
            check("R8", "no second request in flight", pg_valid, 0);
            for (int b = 0; b < chunks[i]; b++) begin
                in_valid = 1;
                in_data = 8'((byte_idx * 7 + 3) & 255);
                #1;
                check("R9", "byte passes", out_valid, 1);
                check("R9", "byte value", out_data, (byte_idx * 7 + 3) & 255);
                byte_idx++;
                @(negedge clk);
            end
            in_valid = 1;
            #1;
            check("R9", "gate closed after chunk", out_valid, 0);
            check("R9", "in_ready low after chunk", in_ready, 0);
            in_valid = 0;
            pg_done = 1;
            pg_status = (i == err_at) ? EW'(code) : '0;
            @(negedge clk);
            pg_done = 0;
            pg_status = '0;
            if (i == err_at) begin
                aborted = 1;
                break;
            end
            committed += chunks[i];
            a += chunks[i];
        end
        begin
            int t = 0;
            while (!rsp_valid && t < 60) begin
                check("R7", "no page request after end", pg_valid, 0);
                @(negedge clk);
                t++;
            end
        end
        exp_status = range_bad ? 1 : (aborted ? 2 : 0);
        check("R10", "reply strobe", rsp_valid, 1);
        if (range_bad)        check("R5", "range status", rsp_status, exp_status);
        else if (aborted)     check("R7", "abort status", rsp_status, exp_status);
        else if (len == 0)    check("R6", "zero length status", rsp_status, exp_status);
        else                  check("R4", "ok status", rsp_status, exp_status);
        check(aborted ? "R7" : (range_bad ? "R5" : "R4"), "committed count", rsp_count,
              range_bad ? 0 : (aborted ? committed : len));
        check(aborted ? "R7" : "R4", "reply code", rsp_code, aborted ? code : 0);
        check("R2", "all chunks used", aborted || range_bad || committed == len, 1);
        @(negedge clk);
        check("R10", "reply one cycle", rsp_valid, 0);
        check("R10", "ready again", req_ready, 1);
    endtask

    task automatic report();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        report();
        $finish;
    end

    initial begin
        in_valid = 1;
        repeat (5) @(negedge clk);
        rst_n = 1;
        #1;
        check("R11", "reset req_ready", req_ready, 1);
        check("R11", "reset pg_valid", pg_valid, 0);
        check("R11", "reset rsp_valid", rsp_valid, 0);
        check("R11", "reset out_valid with input offered", out_valid, 0);
        in_valid = 0;

        do_write(32'h100, 512, -1, 0, 0);   // R3 aligned two pages
        do_write(32'h0F0, 40, -1, 0, 1);    // R1 trimmed first chunk, R8 stall
        do_write(32'h1FE, 300, -1, 0, 0);   // R1 R3 three chunks 2/256/42
        do_write(32'h305, 10, -1, 0, 0);    // R1 inside one page
        do_write(32'h2AB, 0, -1, 0, 0);     // R6 zero length
        do_write(DEV - 4, 8, -1, 0, 0);     // R5 past end
        do_write(DEV - 8, 8, -1, 0, 0);     // R5 exactly at end is fine
        do_write(32'h080, 600, 1, 5, 0);    // R7 abort on second chunk
        do_write(32'h000, 20, 0, 10, 0);    // R7 abort on first chunk
        do_write(32'h7F0, 16, -1, 0, 1);    // R4 after an abort
        report();
        $finish;
    end
endmodule